// File: doc/BRIEF.md
# Spur Detect-and-Cancel Search Controller

This controller runs the digital side of an on-chip spur cancellation loop. For each of a fixed number of targets it programs a low-pass filter cutoff, tracks the filtered energy with a reference DAC, and drives the amplitude and phase words of an auxiliary synthesizer. It reads a single comparator bit that is high while the filtered energy lies above the reference. The analog filter, energy detector and reference DAC are outside the block.

For every target the controller first finds the energy level by a most-significant-bit-first successive approximation. It then lowers the reference by a programmable drop and scans the auxiliary amplitude/phase grid. Whenever the comparator falls low at a grid point (a reversal), the point is recorded and the reference is lowered by one LSB, and the scan starts again. A pass that reaches its scan limit without a reversal ends the target. The last recorded point and a valid flag go into a per-target result slot. These slots can be read back later to reprogram the auxiliary synthesizer without searching again. When the last target is done, the detector enable drops so the analog path can be powered down.

Top module: `spur_search_ctrl`

## Requirements
- R1: After reset busy, det_en, lpf_cut, ref_code, aux_amp and aux_phase are all zero and every result slot reads valid=0.
- R2: busy is high from the cycle after a start pulse seen while idle until the last target completes, and det_en equals busy. A start pulse while busy has no effect: the target sequence does not restart.
- R3: Targets are handled in index order (target i uses bits [6i+5:6i] of tgt_codes). lpf_cut carries the target's 6-bit code, a code of 0 is replaced by 1, and lpf_cut is never 0 while busy.
- R4: Each target's successive approximation starts with a first trial of only the reference MSB (2048 for 12 bits) and proceeds bit by bit toward the LSB. A bit is kept when cmp_hi=1, so the tracked level is one below the energy.
- R5: The tracked level is reduced by ref_drop, saturating at 0. A scan reference of 0 ends the target at once with no reversal possible.
- R6: The scan visits grid index 0,1,2,… where aux_phase is the low 9 bits and aux_amp the high 9 bits. cmp_hi=0 at a point is a reversal: the point is recorded, the reference drops by one and the scan restarts at index 0.
- R7: Each comparator decision is taken on the (settle_cycles+1)-th rising edge after ref_code, aux_amp or aux_phase last changed, and those outputs stay unchanged during the wait.
- R8: A pass without a reversal ends after grid index scan_limit-1 (or the last grid point). A scan_limit of 0 means the whole grid.
- R9: A completed target writes valid=1 with the last recorded amplitude and phase, or valid=0 with zero words if no reversal occurred. A start clears all slots. rd_idx selects the slot shown on rd_valid, rd_amp and rd_phase.
- R10: While idle, det_en, lpf_cut, aux_amp and aux_phase are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search over all targets |
| tgt_codes | input | 24 | Filter cutoff code per target, 6 bits each |
| settle_cycles | input | 16 | Wait before each comparator decision |
| scan_limit | input | 18 | Grid points per pass, 0 = whole grid |
| ref_drop | input | 12 | Reference reduction applied after tracking |
| cmp_hi | input | 1 | Filtered energy is above the reference |
| busy | output | 1 | Search in progress |
| det_en | output | 1 | Enable for the analog detector path |
| lpf_cut | output | 6 | Filter cutoff code |
| ref_code | output | 12 | Reference DAC code |
| aux_amp | output | 9 | Auxiliary amplitude word |
| aux_phase | output | 9 | Auxiliary phase word |
| rd_idx | input | 2 | Result slot select |
| rd_valid | output | 1 | Selected slot holds a detected spur |
| rd_amp | output | 9 | Selected slot amplitude |
| rd_phase | output | 9 | Selected slot phase |

## Verification
A wrong state in the tracker or scan shows at the ports within one settle window. ref_code or the auxiliary words then move at the wrong moment, or the reference steps in the wrong direction. The comparator model in the bench gives inverted answers to any decision taken before the outputs have settled. A decision taken too early therefore corrupts the stored amplitude and phase, which are read back as soon as busy falls. A bad target counter or a restart shows up as a wrong or repeated lpf_cut sequence during the run. A bad saturation or limit shows up as a wrong valid bit or a grid point outside the allowed window.

// File: rtl/spur_pkg.sv
package spur_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SAR,
        ST_SCAN,
        ST_NEXT
    } ctrl_st_e;

endpackage

// File: rtl/spur_settle_timer.sv
module spur_settle_timer #(
    parameter int SET_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SET_W-1:0] settle_cycles,
    output logic             expired
);

    logic [SET_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = settle_cycles;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/spur_result_bank.sv
module spur_result_bank #(
    parameter int NUM_TGT = 4,
    parameter int AMP_W   = 9,
    parameter int PH_W    = 9,
    localparam int TGT_W  = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [TGT_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  logic [AMP_W-1:0] wr_amp,
    input  logic [PH_W-1:0]  wr_phase,
    input  logic [TGT_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [AMP_W-1:0] rd_amp,
    output logic [PH_W-1:0]  rd_phase
);

    typedef struct packed {
        logic             valid;
        logic [AMP_W-1:0] amp;
        logic [PH_W-1:0]  ph;
    } slot_t;

    slot_t              slot_d [NUM_TGT];
    slot_t              slot_q [NUM_TGT];
    logic [NUM_TGT-1:0] valid_vec;

    for (genvar g = 0; g < NUM_TGT; g++) begin : g_slot
        always_comb begin
            slot_d[g] = slot_q[g];
            if (clr) begin
                slot_d[g] = '0;
            end else if (wr_en && (wr_idx == TGT_W'(g))) begin
                slot_d[g] = '{valid: wr_valid, amp: wr_amp, ph: wr_phase};
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q[g] <= '0;
            else        slot_q[g] <= slot_d[g];
        end

        assign valid_vec[g] = slot_q[g].valid;
    end

    assign rd_valid = slot_q[rd_idx].valid;
    assign rd_amp   = slot_q[rd_idx].amp;
    assign rd_phase = slot_q[rd_idx].ph;

    // R9: slots only change on a write or a start clear
    p_slot_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !wr_en) |=> $stable(valid_vec));

endmodule

// File: rtl/spur_search_ctrl.sv
module spur_search_ctrl
    import spur_pkg::*;
#(
    parameter int NUM_TGT = 4,
    parameter int CUT_W   = 6,
    parameter int REF_W   = 12,
    parameter int AMP_W   = 9,
    parameter int PH_W    = 9,
    parameter int SET_W   = 16,
    localparam int TGT_W  = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1,
    localparam int IDX_W  = AMP_W + PH_W,
    localparam int BIT_W  = $clog2(REF_W)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [NUM_TGT*CUT_W-1:0] tgt_codes,
    input  logic [SET_W-1:0]         settle_cycles,
    input  logic [IDX_W-1:0]         scan_limit,
    input  logic [REF_W-1:0]         ref_drop,
    input  logic                     cmp_hi,
    output logic                     busy,
    output logic                     det_en,
    output logic [CUT_W-1:0]         lpf_cut,
    output logic [REF_W-1:0]         ref_code,
    output logic [AMP_W-1:0]         aux_amp,
    output logic [PH_W-1:0]          aux_phase,
    input  logic [TGT_W-1:0]         rd_idx,
    output logic                     rd_valid,
    output logic [AMP_W-1:0]         rd_amp,
    output logic [PH_W-1:0]          rd_phase
);

    typedef struct packed {
        ctrl_st_e         st;
        logic [TGT_W-1:0] tgt;
        logic [CUT_W-1:0] cut;
        logic [REF_W-1:0] ref_v;
        logic [BIT_W-1:0] bitpos;
        logic [IDX_W-1:0] idx;
        logic             found;
        logic [IDX_W-1:0] best;
    } ctrl_t;

    ctrl_t c_d, c_q;

    logic tmr_load, tmr_exp;
    logic res_clr, res_wr;

    function automatic logic [CUT_W-1:0] pick_cut(input logic [CUT_W-1:0] code);
        return (code == '0) ? CUT_W'(1) : code;
    endfunction

    spur_settle_timer #(.SET_W(SET_W)) u_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .load          (tmr_load),
        .settle_cycles (settle_cycles),
        .expired       (tmr_exp)
    );

    always_comb begin
        logic [REF_W-1:0] trial;
        logic [REF_W-1:0] dropped;
        logic [BIT_W-1:0] nb;
        logic [TGT_W-1:0] nt;
        logic [IDX_W-1:0] last_idx;

        c_d      = c_q;
        tmr_load = 1'b0;
        res_clr  = 1'b0;
        res_wr   = 1'b0;
        trial    = c_q.ref_v;
        dropped  = '0;
        nb       = '0;
        nt       = c_q.tgt + 1'b1;
        last_idx = scan_limit - IDX_W'(1);

        case (c_q.st)
            ST_IDLE: begin
                if (start) begin
                    res_clr = 1'b1;
                    c_d.tgt = '0;
                    c_d.cut = pick_cut(tgt_codes[0 +: CUT_W]);
                    c_d.st  = ST_LOAD;
                end
            end
            ST_LOAD: begin
                c_d.ref_v  = '0;
                c_d.ref_v[REF_W-1] = 1'b1;
                c_d.bitpos = BIT_W'(REF_W - 1);
                c_d.idx    = '0;
                c_d.found  = 1'b0;
                c_d.best   = '0;
                tmr_load   = 1'b1;
                c_d.st     = ST_SAR;
            end
            ST_SAR: begin
                if (tmr_exp) begin
                    if (!cmp_hi) trial[c_q.bitpos] = 1'b0;
                    if (c_q.bitpos == '0) begin
                        dropped   = (trial < ref_drop) ? '0 : trial - ref_drop;
                        c_d.ref_v = dropped;
                        c_d.idx   = '0;
                        if (dropped == '0) begin
                            c_d.st = ST_NEXT;
                        end else begin
                            tmr_load = 1'b1;
                            c_d.st   = ST_SCAN;
                        end
                    end else begin
                        nb         = c_q.bitpos - 1'b1;
                        trial[nb]  = 1'b1;
                        c_d.bitpos = nb;
                        c_d.ref_v  = trial;
                        tmr_load   = 1'b1;
                    end
                end
            end
            ST_SCAN: begin
                if (tmr_exp) begin
                    if (!cmp_hi) begin
                        c_d.found = 1'b1;
                        c_d.best  = c_q.idx;
                        c_d.idx   = '0;
                        c_d.ref_v = c_q.ref_v - 1'b1;
                        if (c_q.ref_v == REF_W'(1)) begin
                            c_d.st = ST_NEXT;
                        end else begin
                            tmr_load = 1'b1;
                        end
                    end else if ((c_q.idx == last_idx) || (c_q.idx == '1)) begin
                        c_d.st = ST_NEXT;
                    end else begin
                        c_d.idx  = c_q.idx + 1'b1;
                        tmr_load = 1'b1;
                    end
                end
            end
            ST_NEXT: begin
                res_wr = 1'b1;
                if (c_q.tgt == TGT_W'(NUM_TGT - 1)) begin
                    c_d.st = ST_IDLE;
                end else begin
                    c_d.tgt = nt;
                    c_d.cut = pick_cut(tgt_codes[int'(nt)*CUT_W +: CUT_W]);
                    c_d.st  = ST_LOAD;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    spur_result_bank #(
        .NUM_TGT (NUM_TGT),
        .AMP_W   (AMP_W),
        .PH_W    (PH_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (res_clr),
        .wr_en    (res_wr),
        .wr_idx   (c_q.tgt),
        .wr_valid (c_q.found),
        .wr_amp   (c_q.best[IDX_W-1:PH_W]),
        .wr_phase (c_q.best[PH_W-1:0]),
        .rd_idx   (rd_idx),
        .rd_valid (rd_valid),
        .rd_amp   (rd_amp),
        .rd_phase (rd_phase)
    );

    assign busy      = (c_q.st != ST_IDLE);
    assign det_en    = busy;
    assign lpf_cut   = busy ? c_q.cut : '0;
    assign ref_code  = c_q.ref_v;
    assign aux_amp   = (c_q.st == ST_SCAN) ? c_q.idx[IDX_W-1:PH_W] : '0;
    assign aux_phase = (c_q.st == ST_SCAN) ? c_q.idx[PH_W-1:0]     : '0;

    // R3: a busy controller never presents the unused cutoff code
    p_cut_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (lpf_cut != '0));

    // R6: within a scan the reference only moves downward
    p_ref_falls_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_q.st == ST_SCAN) && ($past(c_q.st) == ST_SCAN)) |-> (ref_code <= $past(ref_code)));

    // R7: outputs held while the settle window runs
    p_settle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (((c_q.st == ST_SCAN) || (c_q.st == ST_SAR)) && !tmr_exp)
            |=> ($stable(ref_code) && $stable(aux_amp) && $stable(aux_phase)));

    // R2: a start pulse during a run leaves the target counter alone
    p_start_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (c_q.st != ST_NEXT)) |=> $stable(c_q.tgt));

    // R10: idle outputs are quiet
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!det_en && (aux_amp == '0) && (aux_phase == '0) && (lpf_cut == '0)));

endmodule

// File: tb/spur_search_ctrl_tb_top.sv
module spur_search_ctrl_tb_top;

    localparam int SETTLE = 2;
    localparam int NRUN   = 3;

    localparam int          RUN_DROP [NRUN] = '{3, 200, 3};
    localparam int          RUN_LIM  [NRUN] = '{600, 600, 500};
    localparam int          EXP_V [NRUN][4] = '{'{1,0,1,1}, '{0,0,0,0}, '{1,0,1,1}};
    localparam int          EXP_A [NRUN][4] = '{'{1,0,0,0}, '{0,0,0,0}, '{0,0,0,0}};
    localparam int          EXP_P [NRUN][4] = '{'{5,0,9,7}, '{0,0,0,0}, '{5,0,9,7}};
    localparam int          EXP_CUT [4]     = '{12, 40, 63, 1};

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [23:0] tgt_codes;
    logic [15:0] settle_cycles;
    logic [17:0] scan_limit;
    logic [11:0] ref_drop;
    logic        cmp_hi;
    logic        busy, det_en;
    logic [5:0]  lpf_cut;
    logic [11:0] ref_code;
    logic [8:0]  aux_amp, aux_phase;
    logic [1:0]  rd_idx;
    logic        rd_valid;
    logic [8:0]  rd_amp, rd_phase;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    spur_search_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .tgt_codes(tgt_codes),
        .settle_cycles(settle_cycles), .scan_limit(scan_limit), .ref_drop(ref_drop),
        .cmp_hi(cmp_hi), .busy(busy), .det_en(det_en), .lpf_cut(lpf_cut),
        .ref_code(ref_code), .aux_amp(aux_amp), .aux_phase(aux_phase),
        .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_amp(rd_amp), .rd_phase(rd_phase)
    );

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // analog stand-in: energy per cutoff as a function of the auxiliary words
    function automatic int energy(input int cut, input int a, input int p);
        case (cut)
            12:      return 100 + iabs(a - 1) + iabs(p - 5);
            40:      return 100;
            63:      return 40 + 20 * a + 2 * iabs(p - 9);
            1:       return 2 + iabs(p - 7) + 10 * a;
            default: return 4000;
        endcase
    endfunction

    // comparator is only trustworthy after SETTLE stable cycles, else inverted
    int          stab = 0;
    logic [29:0] prev_obs = '0;
    logic        ideal;

    always @(negedge clk) begin
        if ({ref_code, aux_amp, aux_phase} != prev_obs) stab <= 0;
        else if (stab < 1000) stab <= stab + 1;
        prev_obs <= {ref_code, aux_amp, aux_phase};
    end

    always_comb begin
        ideal  = energy(int'(lpf_cut), int'(aux_amp), int'(aux_phase)) > int'(ref_code);
        cmp_hi = (stab >= SETTLE) ? ideal : !ideal;
    end

    // observe cutoff sequence and first SAR trial of each target
    int         cut_seq [8];
    int         first_trial [8];
    int         cut_n;
    int         cut_zero;
    logic [5:0] last_cut = '0;
    logic       armed;
    logic [11:0] arm_ref;

    always @(negedge clk) begin
        if (busy) begin
            if (lpf_cut == '0) cut_zero++;
            if (lpf_cut != last_cut) begin
                if (cut_n < 8) cut_seq[cut_n] = int'(lpf_cut);
                cut_n++;
                armed   = 1'b1;
                arm_ref = ref_code;
            end else if (armed && (ref_code != arm_ref)) begin
                if (cut_n > 0 && cut_n <= 8) first_trial[cut_n-1] = int'(ref_code);
                armed = 1'b0;
            end
        end
        last_cut = lpf_cut;
    end

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic run_one(input int r, input bit poke);
        int  n;
        bit  poked;
        string tag;
        tag = (r == 0) ? "R6 R7 R9" : ((r == 1) ? "R5 R9" : "R8 R9");
        ref_drop   = 12'(RUN_DROP[r]);
        scan_limit = 18'(RUN_LIM[r]);
        @(negedge clk);
        cut_n    = 0;
        cut_zero = 0;
        armed    = 1'b0;
        start    = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        rd_idx = 2'd0;
        #1;
        chk("R2 busy one cycle after start", int'(busy), 1);
        chk("R2 det_en follows busy", int'(det_en), 1);
        chk("R9 slot cleared by start", int'(rd_valid), 0);
        n = 0;
        poked = 1'b0;
        while (busy && n < 80000) begin
            @(negedge clk);
            n++;
            if (poke && !poked && lpf_cut == 6'd63) begin
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                poked = 1'b1;
                n++;
            end
        end
        chk("watchdog run finished", int'(!busy), 1);
        for (int t = 0; t < 4; t++) begin
            rd_idx = 2'(t);
            #1;
            chk($sformatf("%s valid run%0d tgt%0d", tag, r, t), int'(rd_valid), EXP_V[r][t]);
            chk($sformatf("%s amp run%0d tgt%0d", tag, r, t), int'(rd_amp), EXP_A[r][t]);
            chk($sformatf("%s phase run%0d tgt%0d", tag, r, t), int'(rd_phase), EXP_P[r][t]);
        end
        chk("R10 det_en low when idle", int'(det_en), 0);
        chk("R10 aux words zero when idle", int'({aux_amp, aux_phase}), 0);
        chk("R10 cutoff zero when idle", int'(lpf_cut), 0);
        chk(poke ? "R2 start while busy ignored (cut count)" : "R3 cutoff count", cut_n, 4);
        chk("R3 no zero cutoff while busy", cut_zero, 0);
        for (int t = 0; t < 4; t++) begin
            chk($sformatf("R3 cutoff of tgt%0d", t), cut_seq[t], EXP_CUT[t]);
            chk($sformatf("R4 first trial of tgt%0d", t), first_trial[t], 2048);
        end
    endtask

    initial begin
        rst_n         = 1'b0;
        start         = 1'b0;
        tgt_codes     = {6'd0, 6'd63, 6'd40, 6'd12};
        settle_cycles = 16'(SETTLE);
        scan_limit    = 18'd600;
        ref_drop      = 12'd3;
        rd_idx        = 2'd0;
        cut_n         = 0;
        cut_zero      = 0;
        armed         = 1'b0;
        arm_ref       = '0;
        for (int i = 0; i < 8; i++) begin
            cut_seq[i]     = 0;
            first_trial[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 det_en", int'(det_en), 0);
        chk("R1 lpf_cut", int'(lpf_cut), 0);
        chk("R1 ref_code", int'(ref_code), 0);
        chk("R1 aux words", int'({aux_amp, aux_phase}), 0);
        for (int t = 0; t < 4; t++) begin
            rd_idx = 2'(t);
            #1;
            chk($sformatf("R1 slot%0d valid", t), int'(rd_valid), 0);
        end

        // table of runs: drop / limit / expected slots
        for (int r = 0; r < NRUN; r++) begin
            run_one(r, r == 2);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule